// File: doc/BRIEF.md
# Colour Expansion Raster-Op Pixel Unit

This block produces one destination pixel per accepted input for a block-transfer engine. Each pixel draws on a full-colour source pixel or on one bit of a monochrome source byte, together with the existing destination pixel, a foreground colour, a background colour and a set of mode controls. Before the result is formed, the source operand can go through colour expansion, bit inversion, transparency or solid fill. A 16-code two-operand raster operation then combines that operand with the destination.

The unit walks through the monochrome bits itself. When a run starts, it begins at a programmable bit position inside the first source byte and then moves one bit per pixel. The feeder learns that a byte is used up through a flag that travels with the last pixel taken from that byte. The pixel can be 8, 16, 24 or 32 bits wide, and the bytes above the selected width leave the unit holding the destination value unchanged. Results are registered: they appear one cycle after the input, with a valid flag and a write enable beside them. Address generation and memory access belong to the surrounding engine.

Top module: `cexp_rop_unit`

## Requirements
- R1: After reset, outValid, outWe and outByteDone are all 0.
- R2: With ceEn=1, fillEn=0 and invEn=0, a selected monochrome bit of 1 makes the source operand fgColor and a bit of 0 makes it bgColor. With ceEn=0 the source operand is srcPix.
- R3: With ceEn=1, invEn=1 flips the selected monochrome bit before the colour is chosen. With ceEn=0, invEn has no effect.
- R4: With ceEn=1, trEn=1 and fillEn=0, a pixel whose effective bit is 0 is produced with outWe=0. Every other pixel, including every pixel with ceEn=0, has outWe=1.
- R5: With ceEn=1 and fillEn=1, the source operand is fgColor whatever the monochrome bit is, and outWe=1.
- R6: ropCode selects the result from destination D and source S. The codes are 0:0, 1:D&S, 2:D&~S, 3:D, 4:~D&S, 5:S, 6:D^S, 7:D|S, 8:~(D|S), 9:~(D^S), A:~S, B:D|~S, C:~D, D:~D|S, E:~(D&S), F:all ones.
- R7: bppSel chooses the pixel width: 0 for 8, 1 for 16, 2 for 24, 3 for 32 bits. Bytes above that width on outPix equal the corresponding bytes of dstPix.
- R8: Monochrome bits are taken most-significant first. A pixel with firstPix=1 uses monoByte[7-startOffs]. Each following valid pixel uses the next lower bit, and after bit 0 the count wraps back to bit 7.
- R9: outByteDone is 1 exactly with a pixel that used bit 0 of monoByte.
- R10: outValid is inValid delayed by one cycle. Cycles with inValid=0 do not advance the monochrome bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A pixel is presented this cycle |
| firstPix | input | 1 | First pixel of a run; reload the bit position |
| startOffs | input | 3 | Starting bit offset inside the first monochrome byte |
| monoByte | input | 8 | Current monochrome source byte |
| srcPix | input | PIX_W | Full-colour source pixel |
| dstPix | input | PIX_W | Existing destination pixel |
| fgColor | input | PIX_W | Foreground colour |
| bgColor | input | PIX_W | Background colour |
| ceEn | input | 1 | Colour expansion enable |
| invEn | input | 1 | Monochrome inversion enable |
| trEn | input | 1 | Transparency enable |
| fillEn | input | 1 | Solid fill enable |
| ropCode | input | 4 | Raster operation code |
| bppSel | input | 2 | Pixel width select |
| outValid | output | 1 | Result valid |
| outPix | output | PIX_W | Resulting pixel |
| outWe | output | 1 | Write enable for the result |
| outByteDone | output | 1 | Result used the last bit of its monochrome byte |

## Verification
The bench keeps the default PIX_BYTES=4. At that value every raster code can be combined with every pixel width, and the byte merge is exercised from one active byte up to four. All sixteen combinations of the four mode controls are run against every start offset over runs that cross a byte boundary, so inversion, transparency, fill and the wrap of the bit position meet one another. Idle cycles placed inside a run show whether the bit position holds still while no pixel is presented.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  typedef struct packed {
    logic fire;
    logic monoBit;
    logic lastBit;
  } seq_strobe_t;
endpackage

// File: rtl/cexp_bit_seq.sv
module cexp_bit_seq
  import cexp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        firstPix,
  input  logic [2:0]  startOffs,
  input  logic [7:0]  monoByte,
  output seq_strobe_t strobe
);
  logic [2:0] curIdx;
  logic [2:0] useIdx;

  assign useIdx = firstPix ? startOffs : curIdx;

  always_comb begin
    strobe.fire    = inValid;
    strobe.monoBit = monoByte[3'd7 - useIdx];
    strobe.lastBit = (useIdx == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curIdx <= '0;
    else if (inValid) curIdx <= useIdx + 3'd1;
  end
endmodule

// File: rtl/cexp_pix_path.sv
module cexp_pix_path
  import cexp_pkg::*;
#(
  parameter int PIX_BYTES = 4,
  localparam int PIX_W = 8 * PIX_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic [PIX_W-1:0] srcPix,
  input  logic [PIX_W-1:0] dstPix,
  input  logic [PIX_W-1:0] fgColor,
  input  logic [PIX_W-1:0] bgColor,
  input  logic             ceEn,
  input  logic             invEn,
  input  logic             trEn,
  input  logic             fillEn,
  input  logic [3:0]       ropCode,
  input  logic [1:0]       bppSel,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outWe,
  output logic             outByteDone
);
  logic             effBit;
  logic [PIX_W-1:0] srcOp;
  logic [PIX_W-1:0] ropRes;
  logic [PIX_W-1:0] merged;
  logic             wrOk;

  assign effBit = strobe.monoBit ^ invEn;

  always_comb begin
    if (!ceEn) srcOp = srcPix;
    else if (fillEn) srcOp = fgColor;
    else srcOp = effBit ? fgColor : bgColor;
    wrOk = !(ceEn && trEn && !fillEn && !effBit);
  end

  always_comb begin
    unique case (ropCode)
      4'h0: ropRes = '0;
      4'h1: ropRes = dstPix & srcOp;
      4'h2: ropRes = dstPix & ~srcOp;
      4'h3: ropRes = dstPix;
      4'h4: ropRes = ~dstPix & srcOp;
      4'h5: ropRes = srcOp;
      4'h6: ropRes = dstPix ^ srcOp;
      4'h7: ropRes = dstPix | srcOp;
      4'h8: ropRes = ~(dstPix | srcOp);
      4'h9: ropRes = ~(dstPix ^ srcOp);
      4'hA: ropRes = ~srcOp;
      4'hB: ropRes = dstPix | ~srcOp;
      4'hC: ropRes = ~dstPix;
      4'hD: ropRes = ~dstPix | srcOp;
      4'hE: ropRes = ~(dstPix & srcOp);
      default: ropRes = '1;
    endcase
  end

  for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = (b <= int'(bppSel)) ? ropRes[b*8 +: 8] : dstPix[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outWe       <= 1'b0;
      outByteDone <= 1'b0;
      outPix      <= '0;
    end else begin
      outValid    <= strobe.fire;
      outWe       <= strobe.fire && wrOk;
      outByteDone <= strobe.fire && strobe.lastBit;
      if (strobe.fire) outPix <= merged;
    end
  end
endmodule

// File: rtl/cexp_rop_unit.sv
module cexp_rop_unit
  import cexp_pkg::*;
#(
  parameter int PIX_BYTES = 4,
  localparam int PIX_W = 8 * PIX_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             firstPix,
  input  logic [2:0]       startOffs,
  input  logic [7:0]       monoByte,
  input  logic [PIX_W-1:0] srcPix,
  input  logic [PIX_W-1:0] dstPix,
  input  logic [PIX_W-1:0] fgColor,
  input  logic [PIX_W-1:0] bgColor,
  input  logic             ceEn,
  input  logic             invEn,
  input  logic             trEn,
  input  logic             fillEn,
  input  logic [3:0]       ropCode,
  input  logic [1:0]       bppSel,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outWe,
  output logic             outByteDone
);
  seq_strobe_t strobe;

  cexp_bit_seq u_seq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .firstPix(firstPix),
    .startOffs(startOffs), .monoByte(monoByte), .strobe(strobe)
  );

  cexp_pix_path #(.PIX_BYTES(PIX_BYTES)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcPix(srcPix), .dstPix(dstPix),
    .fgColor(fgColor), .bgColor(bgColor), .ceEn(ceEn), .invEn(invEn),
    .trEn(trEn), .fillEn(fillEn), .ropCode(ropCode), .bppSel(bppSel),
    .outValid(outValid), .outPix(outPix), .outWe(outWe), .outByteDone(outByteDone)
  );
endmodule

// File: rtl/cexp_rop_checks.sv
module cexp_rop_checks #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             ceEn,
  input logic             fillEn,
  input logic [3:0]       ropCode,
  input logic [1:0]       bppSel,
  input logic [PIX_W-1:0] fgColor,
  input logic [PIX_W-1:0] dstPix,
  input logic             outValid,
  input logic             outWe,
  input logic [PIX_W-1:0] outPix
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_plain_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ceEn) |=> outWe);
  assert_fill_colour_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ceEn && fillEn && ropCode == 4'h5 && bppSel == 2'd3)
      |=> (outWe && outPix == $past(fgColor)));
  assert_keep_dst_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ropCode == 4'h3) |=> outPix == $past(dstPix));
  assert_upper_bytes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bppSel == 2'd0) |=> outPix[PIX_W-1:8] == $past(dstPix[PIX_W-1:8]));
endmodule

bind cexp_rop_unit cexp_rop_checks #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .ceEn(ceEn), .fillEn(fillEn),
  .ropCode(ropCode), .bppSel(bppSel), .fgColor(fgColor), .dstPix(dstPix),
  .outValid(outValid), .outWe(outWe), .outPix(outPix)
);

// File: tb/sim_cexp_rop_unit.sv
`timescale 1ns/1ps
module sim_cexp_rop_unit;
  localparam int PW = 32;
  logic clk = 1'b0;
  logic rstN;
  logic inValid, firstPix, ceEn, invEn, trEn, fillEn;
  logic [2:0] startOffs;
  logic [7:0] monoByte;
  logic [PW-1:0] srcPix, dstPix, fgColor, bgColor;
  logic [3:0] ropCode;
  logic [1:0] bppSel;
  logic outValid, outWe, outByteDone;
  logic [PW-1:0] outPix;

  int checks = 0;
  int failures = 0;
  int bIdx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cexp_rop_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .firstPix(firstPix),
    .startOffs(startOffs), .monoByte(monoByte), .srcPix(srcPix), .dstPix(dstPix),
    .fgColor(fgColor), .bgColor(bgColor), .ceEn(ceEn), .invEn(invEn), .trEn(trEn),
    .fillEn(fillEn), .ropCode(ropCode), .bppSel(bppSel), .outValid(outValid),
    .outPix(outPix), .outWe(outWe), .outByteDone(outByteDone)
  );

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doPix(input string tag, input bit first);
    int idx;
    bit eb;
    logic [PW-1:0] s, r;
    bit we;
    @(negedge clk);
    inValid = 1'b1;
    firstPix = first;
    idx = first ? int'(startOffs) : bIdx;
    bIdx = (idx + 1) % 8;
    eb = monoByte[7 - idx] ^ (ceEn & invEn);
    if (!ceEn) s = srcPix;
    else if (fillEn) s = fgColor;
    else s = eb ? fgColor : bgColor;
    we = !(ceEn && trEn && !fillEn && !eb);
    for (int i = 0; i < PW; i++) begin
      if (i / 8 <= int'(bppSel)) r[i] = ropCode[3 - (2 * int'(dstPix[i]) + int'(s[i]))];
      else r[i] = dstPix[i];
    end
    @(posedge clk);
    #1;
    chk("R10", {31'd0, outValid}, 32'd1);
    chk(tag, outPix, r);
    chk("R4", {31'd0, outWe}, {31'd0, we});
    chk("R9", {31'd0, outByteDone}, {31'd0, idx == 7});
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    monoByte = ~monoByte;
    @(posedge clk);
    #1;
    chk("R10", {31'd0, outValid}, 32'd0);
    monoByte = ~monoByte;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] pats [3];
    pats[0] = 32'hA5C3_0FF0; pats[1] = 32'h1234_5678; pats[2] = 32'hFFFF_0000;
    rstN = 1'b0; inValid = 1'b0; firstPix = 1'b0; startOffs = '0; monoByte = 8'h00;
    srcPix = '0; dstPix = '0; fgColor = '0; bgColor = '0;
    ceEn = 0; invEn = 0; trEn = 0; fillEn = 0; ropCode = '0; bppSel = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {29'd0, outValid, outWe, outByteDone}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R6 / R7: every raster code against every width, plain source
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 3; p++) begin
          ropCode = 4'(op); bppSel = 2'(w);
          srcPix = pats[p]; dstPix = pats[(p + 1) % 3] ^ 32'h3C3C_3C3C;
          invEn = 1'(p); trEn = 1'(p >> 1);
          doPix(w == 3 ? "R6" : "R7", p == 0);
        end

    // R2, R3, R4, R5, R8: mode bits x start offsets over runs crossing a byte
    fgColor = 32'hDEAD_BEEF; bgColor = 32'h0BAD_F00D; dstPix = 32'h5555_AAAA;
    for (int m = 0; m < 16; m++)
      for (int off = 0; off < 8; off++) begin
        ceEn = 1'(m); invEn = 1'(m >> 1); trEn = 1'(m >> 2); fillEn = 1'(m >> 3);
        ropCode = (m % 3 == 0) ? 4'h5 : 4'(m);
        bppSel = 2'(off);
        startOffs = 3'(off);
        monoByte = 8'hB4 ^ 8'(off * 17);
        srcPix = 32'h0F1E_2D3C + PW'(off);
        for (int k = 0; k < 10; k++) begin
          if (bIdx == 0 && k != 0) monoByte = monoByte + 8'h3B;
          doPix(fillEn ? "R5" : (invEn ? "R3" : (off != 0 ? "R8" : "R2")), k == 0);
        end
      end

    // R10: idle cycles inside a run keep the bit position
    ceEn = 1; invEn = 0; trEn = 1; fillEn = 0; ropCode = 4'h5; bppSel = 2'd3;
    monoByte = 8'b1001_0110; startOffs = 3'd2;
    doPix("R8", 1'b1);
    for (int k = 0; k < 5; k++) begin
      idle();
      doPix("R10", 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule